// File: doc/BRIEF.md
# Keyed Configuration Port Unlock

This block sits on the peripheral side of an 8-bit I/O bus with a 16-bit address and holds a small file of configuration bytes. After reset the file is hidden. A host opens it by writing a fixed five-byte key across two fixed unlock ports. The last two bytes of that key carry a base byte and then its bitwise complement. The base byte, shifted left by two, gives the address of an index port, and the data port sits one address above it. The power-on base byte 0xE4 places the two ports at 0x390 and 0x391.

While the block is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. One register reports the stored base byte, so that software can find the device. The host closes the block by selecting the exit index and writing zero to the data port. Register contents survive a relock and a later unlock.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is locked and the stored base byte is 0xE4. Reads of 0x390 and 0x391 return 0xFF.
- R2: The unlock key is five writes in this order: 0x55 to the first unlock port (0x2FA), then 0xAA, 0x36 and the base byte to the second unlock port (0x3FA), then the complement of that base byte to the first unlock port. The block is unlocked from the clock edge that takes the fifth write.
- R3: Any write during the key that has the wrong address or the wrong value sends the sequencer back to idle. The breaking write starts nothing, so the key must begin again with 0x55. Reads never disturb the sequence.
- R4: When unlocked, the index port is at the base byte shifted left by 2 and the data port at that address plus 1. Unlocking with a new base byte moves both ports, and the old addresses then read 0xFF.
- R5: While locked, reads of the index and data ports return 0xFF and writes to them change nothing.
- R6: When unlocked, a write to the data port stores the byte in the register selected by the index (0x00 to 0x0F), and a later read returns it. All registers reset to 0x00 and keep their values across relock.
- R7: A read of the index port returns the last index written. The index is 0x00 whenever the block has just been unlocked.
- R8: Register 0x0E is read-only and returns the stored base byte. Writes to it are ignored.
- R9: With an index of 0x10 or above, data port reads return 0xFF and data port writes change no register.
- R10: With index 0x0F selected, a data write of 0x00 relocks the block at that edge. A nonzero data write to index 0x0F is stored in register 0x0F and the block stays unlocked.
- R11: io_rdata is combinational. A read in the same cycle as a write returns the state from before that write's clock edge.
- R12: While unlocked, writes to the unlock ports have no effect, and a full key sent then neither relocks the block nor changes the base byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when nothing responds |

## Verification
Two functions can meet in one cycle: a data port read and a data port write to the same address. This covers both an ordinary register write and the zero write that relocks the block. The bench raises io_rd and io_wr together on the data port and samples io_rdata before the clock edge, expecting the old register value. It then reads again after the edge and expects the new value, or 0xFF when the write was the exit. The rest of the stimulus is a seeded mix: random register writes, read-back against a shadow model, and broken keys at each of the five steps.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

    localparam logic [7:0] KEY_1      = 8'h55;
    localparam logic [7:0] KEY_2      = 8'hAA;
    localparam logic [7:0] KEY_3      = 8'h36;
    localparam logic [7:0] EXIT_INDEX = 8'h0F;
    localparam logic [7:0] BASE_INDEX = 8'h0E;
    localparam logic [7:0] IDLE_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_KEY3,
        SQ_BASE
    } seq_state_e;

    typedef struct packed {
        seq_state_e nxt;
        logic       take_base;
        logic       open;
    } seq_step_t;

    // One step of the key sequencer, evaluated on every locked write.
    function automatic seq_step_t seq_step(seq_state_e s, logic hit_a, logic hit_b,
                                           logic [7:0] d, logic [7:0] cand);
        seq_step_t r;
        r.nxt       = SQ_IDLE;
        r.take_base = 1'b0;
        r.open      = 1'b0;
        case (s)
            SQ_IDLE: if (hit_a && d == KEY_1) r.nxt = SQ_KEY1;
            SQ_KEY1: if (hit_b && d == KEY_2) r.nxt = SQ_KEY2;
            SQ_KEY2: if (hit_b && d == KEY_3) r.nxt = SQ_KEY3;
            SQ_KEY3: if (hit_b) begin
                r.nxt       = SQ_BASE;
                r.take_base = 1'b1;
            end
            SQ_BASE: if (hit_a && d == ~cand) r.open = 1'b1;
            default: r.nxt = SQ_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgu_seq.sv
module cfgu_seq
    import cfgu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PORT_A   = 16'h2FA,
    parameter int unsigned PORT_B   = 16'h3FA,
    parameter logic [7:0]  DEF_BASE = 8'hE4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    input  logic              exit_stb,
    output logic              cfg_open,
    output logic [7:0]        base_byte
);
    seq_state_e state_q;
    logic [7:0] cand_q;
    logic       hit_a, hit_b;
    seq_step_t  step;

    assign hit_a = (io_addr == ADDR_W'(PORT_A));
    assign hit_b = (io_addr == ADDR_W'(PORT_B));
    assign step  = seq_step(state_q, hit_a, hit_b, io_wdata, cand_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            cand_q    <= 8'h00;
            cfg_open  <= 1'b0;
            base_byte <= DEF_BASE;
        end else if (cfg_open) begin
            state_q <= SQ_IDLE;
            if (exit_stb) cfg_open <= 1'b0;
        end else if (io_wr) begin
            state_q <= step.nxt;
            if (step.take_base) cand_q <= io_wdata;
            if (step.open) begin
                cfg_open  <= 1'b1;
                base_byte <= cand_q;
            end
        end
    end

    // R2: unlocking only follows a write to the first unlock port
    assert_open_from_port_a_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> ($past(io_wr) && $past(io_addr) == ADDR_W'(PORT_A)));
    // R10: exit strobe relocks at the next edge
    assert_exit_relocks_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && exit_stb) |=> !cfg_open);
    // R12: unlocked state is held without an exit
    assert_open_held_R12: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && !exit_stb) |=> cfg_open);
    // R8: base byte changes only on unlock
    assert_base_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !$rose(cfg_open) |-> $stable(base_byte));
endmodule

// File: rtl/cfgu_regs.sv
module cfgu_regs #(
    parameter int unsigned REG_COUNT = 16,
    localparam int unsigned IDX_W    = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                             mem[g] <= 8'h00;
            else if (we && idx == IDX_W'(g))     mem[g] <= wdata;
        end
    end

    assign rdata = mem[idx];

    // R6: a stored byte is readable from its slot on the next cycle
    assert_store_R6: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/cfgu_decode.sv
module cfgu_decode
    import cfgu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BASE_SHIFT = 2,
    parameter int unsigned REG_COUNT  = 16,
    localparam int unsigned IDX_W     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              cfg_open,
    input  logic [7:0]        base_byte,
    input  logic [7:0]        rf_rdata,
    output logic              exit_stb,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [7:0]        io_rdata
);
    logic [7:0]        idx_q;
    logic [ADDR_W-1:0] idx_addr, data_addr;
    logic              hit_idx, hit_data, idx_valid;

    assign idx_addr  = ADDR_W'(base_byte) << BASE_SHIFT;
    assign data_addr = idx_addr + ADDR_W'(1);
    assign hit_idx   = cfg_open && (io_addr == idx_addr);
    assign hit_data  = cfg_open && (io_addr == data_addr);
    assign idx_valid = (idx_q < 8'(REG_COUNT));
    assign rf_idx    = idx_q[IDX_W-1:0];

    assign exit_stb = io_wr && hit_data && idx_q == EXIT_INDEX && io_wdata == 8'h00;
    assign rf_we    = io_wr && hit_data && idx_valid && idx_q != BASE_INDEX && !exit_stb;

    always_ff @(posedge clk) begin
        if (rst || !cfg_open)        idx_q <= 8'h00;
        else if (io_wr && hit_idx)   idx_q <= io_wdata;
    end

    always_comb begin
        io_rdata = IDLE_BYTE;
        if (io_rd && hit_idx) begin
            io_rdata = idx_q;
        end else if (io_rd && hit_data && idx_valid) begin
            io_rdata = (idx_q == BASE_INDEX) ? base_byte : rf_rdata;
        end
    end

    // R5: nothing answers while locked
    assert_locked_float_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> (io_rdata == IDLE_BYTE));
    // R7: index is zero on the first unlocked cycle
    assert_index_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> (idx_q == 8'h00));
    // R9: out-of-range index never writes
    assert_range_R9: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> idx_valid);
    // R10: exit and store are exclusive
    assert_exit_no_store_R10: assert property (@(posedge clk) disable iff (rst)
        exit_stb |-> !rf_we);
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import cfgu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned KEY_PORT_A = 16'h2FA,
    parameter int unsigned KEY_PORT_B = 16'h3FA,
    parameter int unsigned BASE_SHIFT = 2,
    parameter logic [7:0]  DEF_BASE   = 8'hE4,
    parameter int unsigned REG_COUNT  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    localparam int unsigned IDX_W = $clog2(REG_COUNT);

    logic             cfg_open, exit_stb, rf_we;
    logic [7:0]       base_byte, rf_rdata;
    logic [IDX_W-1:0] rf_idx;

    cfgu_seq #(
        .ADDR_W(ADDR_W), .PORT_A(KEY_PORT_A), .PORT_B(KEY_PORT_B), .DEF_BASE(DEF_BASE)
    ) u_seq (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .exit_stb(exit_stb), .cfg_open(cfg_open), .base_byte(base_byte)
    );

    cfgu_decode #(
        .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .REG_COUNT(REG_COUNT)
    ) u_dec (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .cfg_open(cfg_open), .base_byte(base_byte),
        .rf_rdata(rf_rdata), .exit_stb(exit_stb), .rf_we(rf_we), .rf_idx(rf_idx),
        .io_rdata(io_rdata)
    );

    cfgu_regs #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk(clk), .rst(rst), .we(rf_we), .idx(rf_idx), .wdata(io_wdata), .rdata(rf_rdata)
    );
endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
    localparam logic [15:0] PA = 16'h2FA;
    localparam logic [15:0] PB = 16'h3FA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [7:0] shadow [16];
    logic [7:0] exp_base;

    keyed_cfg_port dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] idx_port(input logic [7:0] b);
        return {6'b0, b, 2'b00};
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] idx);
        if (idx >= 8'd16)  return 8'hFF;
        if (idx == 8'h0E)  return exp_base;
        return shadow[idx[3:0]];
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    // bad_step < 0: clean key. bad_kind 0: wrong value, 1: wrong port.
    task automatic send_key(input logic [7:0] b, input int bad_step, input int bad_kind);
        logic [15:0] a [5];
        logic [7:0]  d [5];
        logic [7:0]  tmp;
        a = '{PA, PB, PB, PB, PA};
        d = '{8'h55, 8'hAA, 8'h36, b, ~b};
        for (int s = 0; s < 5; s++) begin
            logic [15:0] aa = a[s];
            logic [7:0]  dd = d[s];
            if (s == bad_step) begin
                if (bad_kind == 0) dd = dd ^ 8'h01;
                else aa = (aa == PA) ? PB : PA;
            end
            bus_wr(aa, dd);
            if (s == 2) bus_rd(PB, tmp);   // reads must not disturb the key
        end
    endtask

    task automatic set_reg(input logic [7:0] b, input logic [7:0] idx, input logic [7:0] v);
        bus_wr(idx_port(b), idx);
        bus_wr(idx_port(b) + 16'd1, v);
    endtask

    task automatic get_reg(input logic [7:0] b, input logic [7:0] idx, output logic [7:0] v);
        bus_wr(idx_port(b), idx);
        bus_rd(idx_port(b) + 16'd1, v);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd20251));
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        exp_base = 8'hE4;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(16'h390, v); chk("R1 index port locked", v, 8'hFF);
        bus_rd(16'h391, v); chk("R1 data port locked", v, 8'hFF);

        // R5 locked writes ignored
        bus_wr(16'h390, 8'h03);
        bus_wr(16'h391, 8'h77);

        // R3 broken keys at every step, then the rest of the key sent cleanly
        for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 5; s++) begin
                if (!(k == 0 && s == 3)) begin
                    send_key(8'hE4, s, k);
                    bus_rd(16'h390, v);
                    chk($sformatf("R3 broken step %0d kind %0d", s, k), v, 8'hFF);
                end
            end
        end

        // R2 clean unlock, R7 index cleared, R8 base report, R5 earlier writes absent
        send_key(8'hE4, -1, 0);
        bus_rd(16'h390, v); chk("R7 index zero after unlock", v, 8'h00);
        bus_rd(16'h391, v); chk("R5 locked data write ignored", v, 8'h00);
        get_reg(8'hE4, 8'h0E, v); chk("R2 R8 base register", v, 8'hE4);
        set_reg(8'hE4, 8'h0E, 8'h11);
        get_reg(8'hE4, 8'h0E, v); chk("R8 base register read-only", v, 8'hE4);
        bus_rd(16'h390, v); chk("R7 index readback", v, 8'h0E);

        // R6 random writes and read-back
        for (int n = 0; n < 40; n++) begin
            logic [7:0] ix = 8'($urandom_range(0, 15));
            logic [7:0] dv = 8'($urandom);
            if (ix == 8'h0F && dv == 8'h00) dv = 8'h5A;
            set_reg(8'hE4, ix, dv);
            if (ix != 8'h0E) shadow[ix[3:0]] = dv;
        end
        for (int i = 0; i < 16; i++) begin
            get_reg(8'hE4, 8'(i), v);
            chk($sformatf("R6 readback reg %0d", i), v, exp_data(8'(i)));
        end

        // R9 out-of-range index
        set_reg(8'hE4, 8'h20, 8'hC3);
        get_reg(8'hE4, 8'h20, v); chk("R9 out-of-range read", v, 8'hFF);
        get_reg(8'hE4, 8'h00, v); chk("R9 no alias write", v, shadow[0]);

        // R12 key while unlocked has no effect
        send_key(8'h40, -1, 0);
        get_reg(8'hE4, 8'h0E, v); chk("R12 base unchanged", v, 8'hE4);

        // R11 same-cycle read and write of a register
        bus_wr(16'h390, 8'h03);
        @(negedge clk);
        io_addr = 16'h391; io_wdata = 8'hA7; io_wr = 1'b1; io_rd = 1'b1;
        #1 chk("R11 read before write edge", io_rdata, shadow[3]);
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
        shadow[3] = 8'hA7;
        bus_rd(16'h391, v); chk("R11 read after write edge", v, 8'hA7);

        // R10 nonzero write at exit index stays unlocked
        set_reg(8'hE4, 8'h0F, 8'h3C); shadow[15] = 8'h3C;
        get_reg(8'hE4, 8'h0F, v); chk("R10 nonzero exit write stored", v, 8'h3C);

        // R10 R11 exit write with a read in the same cycle
        @(negedge clk);
        io_addr = 16'h391; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
        #1 chk("R11 exit cycle still unlocked", io_rdata, 8'h3C);
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
        bus_rd(16'h391, v); chk("R10 relocked data port", v, 8'hFF);
        bus_rd(16'h390, v); chk("R10 relocked index port", v, 8'hFF);

        // R4 relocation with a new base, R6 retention across relock
        send_key(8'h40, -1, 0);
        exp_base = 8'h40;
        bus_rd(16'h390, v); chk("R4 old index port silent", v, 8'hFF);
        bus_rd(16'h100, v); chk("R4 new index port", v, 8'h00);
        get_reg(8'h40, 8'h0E, v); chk("R4 R8 new base reported", v, 8'h40);
        get_reg(8'h40, 8'h03, v); chk("R6 retained across relock", v, shadow[3]);
        set_reg(8'h40, 8'h0F, 8'h00);
        bus_rd(16'h100, v); chk("R10 relock at new base", v, 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule